// File: doc/BRIEF.md
# Encoder Reply Frame Receiver

This block listens on the receive side of an RS-485 link to an absolute rotary encoder. It takes the reply that the encoder sends after the requester has issued its command. A one-cycle `start_i` pulse arms the receiver and wipes the previous result. The receiver then waits for the leading control field and checks its sync pattern and parity. It decodes the command ID carried in that field and uses it to work out how many data fields will follow. After that it stores the status byte, each data byte and the CRC byte in their own output registers.

The receive line is retimed through two flops. Each bit is sampled at its midpoint, and the bit period is a whole number of system clocks. With a 2.5 Mbit/s line and a 200 MHz system clock, `CLKS_PER_BIT` is 80. When the line goes quiet for too long, the frame is abandoned. Any failure is reported on a three-bit error vector. A frame that arrives complete and clean ends with a one-cycle `done_o` pulse. The CRC value is only captured here; computing and comparing it is left to logic outside this block.

Top module: `enc_reply_rx`

## Requirements
- R1: While `rst` is high at a clock edge, every output register clears to 0: `id_o`, `status_o`, `data_o`, `crc_o`, `err_o` and `done_o`.
- R2: Every field is 10 bits long. It is a low start bit, then eight payload bits with the least significant first, then a high delimiter. Each bit lasts `CLKS_PER_BIT` clocks. The line passes through two flops and is sampled `CLKS_PER_BIT/2` clocks into each bit.
- R3: The control field carries its bits on the line in this order: the sync bits 0,0,1,0, then the 4-bit ID with the least significant bit first, then a parity bit equal to the XOR of the four ID bits, then a high delimiter. A clean control field places the ID on `id_o`.
- R4: The ID sets how many data fields follow the status field. IDs 0 and 1 give 3. ID 2 gives 1. ID 3 gives 8. IDs 7, 8 and 12 give 3. The reply is always the control field, the status field, the data fields and then the CRC field.
- R5: The status payload appears on `status_o`. Data field k appears on `data_o[8k+7:8k]`. The CRC payload appears on `crc_o`.
- R6: A `start_i` pulse clears `err_o`, `id_o`, `status_o`, `data_o` and `crc_o` one cycle later. Data slots that the next reply does not fill stay 0.
- R7: If the control-field parity bit does not match, `err_o[0]` is set.
- R8: `err_o[1]` is set in three cases. The first is a sync pattern other than 0,0,1,0. The second is an ID not listed in R4. The third is that no control field begins within `GAP_TIMEOUT` clocks after `start_i`.
- R9: `err_o[2]` is set in two cases. The first is any field whose delimiter is sampled low, which is what a line stuck low produces. The second is the line staying idle for `GAP_TIMEOUT` clocks between the end of one field and the start of the next.
- R10: `done_o` is high for exactly one cycle, in the cycle the CRC byte is stored, and only for a reply with no error.
- R11: After an error, reception stops. Fields that arrive later leave every output unchanged until the next `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle pulse that arms reception of a new reply |
| rx_i | input | 1 | Serial receive line, idle high |
| id_o | output | 4 | ID decoded from the control field |
| status_o | output | 8 | Status field payload |
| data_o | output | 64 | Data field payloads; field k sits at bits 8k+7:8k |
| crc_o | output | 8 | CRC field payload as received |
| err_o | output | 3 | Error flags: [0] parity, [1] bad start, [2] incomplete |
| done_o | output | 1 | One-cycle pulse when a clean reply is complete |

## Verification
Suppose a field's start bit is put on the line just after clock edge k. The sync flops, the half-bit wait, nine further bit periods and the field decode then place that field's effect on the outputs after edge k + 4 + CLKS_PER_BIT/2 + 9·CLKS_PER_BIT. A start pulse or a reset seen at edge k clears the outputs after edge k+1. A timeout takes effect `GAP_TIMEOUT`+1 edges after the edge that cleared the gap count. That edge is either the start edge or the edge of the last delimiter sample. The bench keeps a behavioural model that turns every field it sends into events stamped with these due cycles. Each clock it applies the events that have fallen due and compares every output against the model.

// File: rtl/enc_reply_pkg.sv
package enc_reply_pkg;

  localparam int unsigned MAX_DATA   = 8;
  localparam int unsigned FIELD_BITS = 10;
  localparam int unsigned BYTE_W     = 8;

  // sync bits arrive first on the line: 0,0,1,0 -> vector bit 0 is the first
  localparam logic [3:0] SYNC_PAT = 4'b0100;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAITCF = 2'd1,
    ST_BODY   = 2'd2
  } rx_state_t;

  // number of data fields carried by a reply for a given command ID, 0 = unknown ID
  function automatic logic [3:0] data_count(input logic [3:0] id);
    case (id)
      4'h0, 4'h1: data_count = 4'd3;
      4'h2:       data_count = 4'd1;
      4'h3:       data_count = 4'd8;
      4'h7, 4'h8, 4'hC: data_count = 4'd3;
      default:    data_count = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/erx_bit_sampler.sv
module erx_bit_sampler
  import enc_reply_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 80
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rx_i,
  input  logic                  hunt,
  input  logic                  abort,
  output logic                  busy,
  output logic                  fld_valid,
  output logic [FIELD_BITS-1:0] fld_bits
);

  localparam int unsigned CW = $clog2(CLKS_PER_BIT);
  localparam logic [CW-1:0] HALF_M1 = CW'(CLKS_PER_BIT / 2 - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(CLKS_PER_BIT - 1);
  localparam logic [3:0]    LAST_IX = 4'(FIELD_BITS - 1);

  logic                  s1, s2;
  logic [CW-1:0]         phase;
  logic [3:0]            bix;
  logic [FIELD_BITS-1:0] shf;

  // two-flop retiming of the asynchronous line
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rx_i;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy      <= 1'b0;
      phase     <= '0;
      bix       <= '0;
      shf       <= '0;
      fld_valid <= 1'b0;
      fld_bits  <= '0;
    end else begin
      fld_valid <= 1'b0;
      if (!busy) begin
        if (hunt && !s2) begin
          busy  <= 1'b1;
          phase <= HALF_M1;
          bix   <= '0;
        end
      end else if (phase == '0) begin
        shf   <= {s2, shf[FIELD_BITS-1:1]};
        phase <= FULL_M1;
        if (bix == LAST_IX) begin
          busy      <= 1'b0;
          fld_valid <= 1'b1;
          fld_bits  <= {s2, shf[FIELD_BITS-1:1]};
        end else begin
          bix <= bix + 4'd1;
        end
      end else begin
        phase <= phase - 1'b1;
      end
    end
  end

endmodule

// File: rtl/erx_gap_timer.sv
module erx_gap_timer #(
  parameter int unsigned GAP_TIMEOUT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);

  localparam int unsigned CW = $clog2(GAP_TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(GAP_TIMEOUT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear || !run) cnt <= '0;
    else if (cnt != LIMIT)    cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LIMIT);

endmodule

// File: rtl/enc_reply_rx.sv
module enc_reply_rx
  import enc_reply_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 80,
  parameter int unsigned GAP_TIMEOUT  = 1000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_i,
  input  logic                       rx_i,
  output logic [3:0]                 id_o,
  output logic [BYTE_W-1:0]          status_o,
  output logic [MAX_DATA*BYTE_W-1:0] data_o,
  output logic [BYTE_W-1:0]          crc_o,
  output logic [2:0]                 err_o,
  output logic                       done_o
);

  rx_state_t             state_q;
  logic [3:0]            fidx, nfld;
  logic                  smp_busy, fld_valid, expired, hunt, waiting;
  logic [FIELD_BITS-1:0] fld_bits;
  logic [BYTE_W-1:0]     fld_byte;
  logic [2:0]            cf_err;
  logic                  body_err, take, is_stat, is_crc, is_dat;

  assign waiting = (state_q != ST_IDLE);
  // no new field may begin in the cycle a field or a timeout is being resolved
  assign hunt    = waiting && !fld_valid && !expired;

  erx_bit_sampler #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_smp (
    .clk(clk), .rst(rst), .rx_i(rx_i), .hunt(hunt), .abort(start_i),
    .busy(smp_busy), .fld_valid(fld_valid), .fld_bits(fld_bits)
  );

  erx_gap_timer #(.GAP_TIMEOUT(GAP_TIMEOUT)) u_gap (
    .clk(clk), .rst(rst), .clear(start_i),
    .run(waiting && !smp_busy), .expired(expired)
  );

  assign fld_byte = fld_bits[8:1];

  always_comb begin
    cf_err[0] = fld_bits[8] != ^fld_bits[7:4];
    cf_err[1] = (fld_bits[3:0] != SYNC_PAT) || (data_count(fld_bits[7:4]) == 4'd0);
    cf_err[2] = !fld_bits[9];
    body_err  = !fld_bits[9] || fld_bits[0];
    take      = (state_q == ST_BODY) && fld_valid && !expired && !body_err;
    is_stat   = (fidx == 4'd0);
    is_crc    = (fidx == nfld + 4'd1);
    is_dat    = !is_stat && (fidx <= nfld);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      fidx     <= '0;
      nfld     <= '0;
      id_o     <= '0;
      status_o <= '0;
      crc_o    <= '0;
      err_o    <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        state_q  <= ST_WAITCF;
        fidx     <= '0;
        nfld     <= '0;
        id_o     <= '0;
        status_o <= '0;
        crc_o    <= '0;
        err_o    <= '0;
      end else begin
        case (state_q)
          ST_WAITCF: begin
            if (expired) begin
              err_o[1] <= 1'b1;
              state_q  <= ST_IDLE;
            end else if (fld_valid) begin
              if (|cf_err) begin
                err_o   <= cf_err;
                state_q <= ST_IDLE;
              end else begin
                id_o    <= fld_bits[7:4];
                nfld    <= data_count(fld_bits[7:4]);
                fidx    <= '0;
                state_q <= ST_BODY;
              end
            end
          end
          ST_BODY: begin
            if (expired || (fld_valid && body_err)) begin
              err_o[2] <= 1'b1;
              state_q  <= ST_IDLE;
            end else if (take) begin
              fidx <= fidx + 4'd1;
              if (is_stat) status_o <= fld_byte;
              if (is_crc) begin
                crc_o   <= fld_byte;
                done_o  <= 1'b1;
                state_q <= ST_IDLE;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // one holding register per data slot
  for (genvar gi = 0; gi < MAX_DATA; gi++) begin : g_dat
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst || start_i)                          q <= '0;
      else if (take && is_dat && fidx == 4'(gi + 1)) q <= fld_byte;
    end
    assign data_o[gi*BYTE_W +: BYTE_W] = q;
  end

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_clean_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (err_o == 3'b000));

  assert_start_clears_R6: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (err_o == 3'b000 && status_o == '0 && crc_o == '0 && data_o == '0));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> !smp_busy);

  assert_known_id_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (data_count(id_o) != 4'd0));

endmodule

// File: tb/sim_enc_reply_rx.sv
module sim_enc_reply_rx;

  localparam int CLK_T = 10;
  localparam int CPB   = 8;
  localparam int TMO   = 40;
  localparam int HB    = CPB / 2;
  localparam int LAT   = 4 + HB + 9 * CPB;

  logic        clk, rst, start_i, rx_i;
  logic [3:0]  id_o;
  logic [7:0]  status_o, crc_o;
  logic [63:0] data_o;
  logic [2:0]  err_o;
  logic        done_o;

  enc_reply_rx #(.CLKS_PER_BIT(CPB), .GAP_TIMEOUT(TMO)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .rx_i(rx_i),
    .id_o(id_o), .status_o(status_o), .data_o(data_o), .crc_o(crc_o),
    .err_o(err_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #(CLK_T / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; int kind; int idx; int val; } ev_t;
  ev_t evq[$];

  // expected outputs
  logic [3:0]  e_id = '0;
  logic [7:0]  e_st = '0, e_crc = '0;
  logic [63:0] e_dat = '0;
  logic [2:0]  e_err = '0;
  logic        e_done = 1'b0;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    finished = 0;

  // model of the receive sequence, advanced when each field is sent
  int m_st = 0, m_n = 0, m_f = 0, m_gap = 0;

  function automatic int ref_len(input logic [3:0] id);
    case (id)
      4'd0, 4'd1, 4'd7, 4'd8, 4'd12: return 3;
      4'd2: return 1;
      4'd3: return 8;
      default: return 0;
    endcase
  endfunction

  task automatic push(input int due, input int kind, input int idx, input int val);
    ev_t e;
    e.due = due; e.kind = kind; e.idx = idx; e.val = val;
    evq.push_back(e);
  endtask

  task automatic mdl_field(input int k, input logic [9:0] b);
    int due;
    int er;
    due = k + LAT;
    if (m_st == 1) begin
      er = 0;
      if (b[3:0] != 4'b0100 || ref_len(b[7:4]) == 0) er |= 2;
      if (b[8] != (b[4] ^ b[5] ^ b[6] ^ b[7]))       er |= 1;
      if (!b[9])                                      er |= 4;
      if (er != 0) begin push(due, 5, 0, er); m_st = 0; end
      else begin push(due, 1, 0, int'(b[7:4])); m_n = ref_len(b[7:4]); m_f = 0; m_st = 2; end
    end else if (m_st == 2) begin
      if (!b[9] || b[0]) begin push(due, 5, 0, 4); m_st = 0; end
      else begin
        if (m_f == 0)        push(due, 2, 0, int'(b[8:1]));
        else if (m_f <= m_n) push(due, 3, m_f - 1, int'(b[8:1]));
        else begin           push(due, 4, 0, int'(b[8:1])); m_st = 0; end
        m_f++;
      end
    end
    m_gap = k + 3 + HB + 9 * CPB;
  endtask

  task automatic mdl_stall();
    if (m_st == 1)      push(m_gap + TMO + 1, 5, 0, 2);
    else if (m_st == 2) push(m_gap + TMO + 1, 5, 0, 4);
    m_st = 0;
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    e_done = 1'b0;
    for (int i = evq.size() - 1; i >= 0; i--) begin
      if (evq[i].due == cyc) begin
        case (evq[i].kind)
          0: begin e_id = '0; e_st = '0; e_dat = '0; e_crc = '0; e_err = '0; end
          1: e_id = 4'(evq[i].val);
          2: e_st = 8'(evq[i].val);
          3: e_dat[evq[i].idx*8 +: 8] = 8'(evq[i].val);
          4: begin e_crc = 8'(evq[i].val); e_done = 1'b1; end
          default: e_err = e_err | 3'(evq[i].val);
        endcase
        evq.delete(i);
      end
    end
    n_cmp++;
    if ({id_o, status_o, data_o, crc_o, err_o, done_o} !==
        {e_id, e_st, e_dat, e_crc, e_err, e_done}) begin
      n_bad++;
      $display("FAIL %s cyc=%0d actual id=%h st=%h d=%h crc=%h err=%b done=%b expected id=%h st=%h d=%h crc=%h err=%b done=%b",
               cur_req, cyc, id_o, status_o, data_o, crc_o, err_o, done_o,
               e_id, e_st, e_dat, e_crc, e_err, e_done);
    end
  end

  task automatic send_field(input logic [9:0] f, output int k);
    @(posedge clk); #1;
    k = cyc;
    for (int b = 0; b < 10; b++) begin
      rx_i = f[b];
      repeat (CPB) @(posedge clk);
      #1;
    end
    rx_i = 1'b1;
  endtask

  task automatic do_start();
    @(posedge clk); #1;
    start_i = 1'b1;
    push(cyc + 1, 0, 0, 0);
    m_st = 1;
    m_gap = cyc + 1;
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1;
    push(cyc + 1, 0, 0, 0);
    m_st = 0;
    @(posedge clk); #1;
    rst = 1'b0;
  endtask

  // nsend: fields sent after the control field; bad_dl: index of field with low delimiter
  task automatic run_frame(input logic [3:0] id, input logic [3:0] sync, input bit pflip,
                           input int nsend, input int bad_dl, input int seed);
    int k, n;
    logic [9:0] cf;
    logic [7:0] by;
    do_start();
    n  = (ref_len(id) == 0) ? 3 : ref_len(id);
    cf = {1'b1, (id[0] ^ id[1] ^ id[2] ^ id[3]) ^ pflip, id, sync};
    send_field(cf, k);
    mdl_field(k, cf);
    for (int f = 0; f < n + 2 && f < nsend; f++) begin
      by = 8'((seed * 53 + f * 29 + 7) & 255);
      send_field({(f == bad_dl) ? 1'b0 : 1'b1, by, 1'b0}, k);
      mdl_field(k, {(f == bad_dl) ? 1'b0 : 1'b1, by, 1'b0});
    end
    if (nsend < n + 2) begin
      mdl_stall();
      repeat (TMO + 20) @(posedge clk);
    end else begin
      repeat (LAT) @(posedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired during %s", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int k;
    rst = 1'b1; start_i = 1'b0; rx_i = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    repeat (6) @(posedge clk);

    cur_req = "R2 R3 R4 R5 R10 ID0";
    run_frame(4'd0, 4'b0100, 1'b0, 99, -1, 1);
    cur_req = "R4 R5 R10 ID3";
    run_frame(4'd3, 4'b0100, 1'b0, 99, -1, 2);
    cur_req = "R6 R4 ID2 short frame clears slots";
    run_frame(4'd2, 4'b0100, 1'b0, 99, -1, 3);
    cur_req = "R4 ID1";
    run_frame(4'd1, 4'b0100, 1'b0, 99, -1, 4);
    cur_req = "R4 ID7";
    run_frame(4'd7, 4'b0100, 1'b0, 99, -1, 5);
    cur_req = "R4 ID8";
    run_frame(4'd8, 4'b0100, 1'b0, 99, -1, 6);
    cur_req = "R4 ID12";
    run_frame(4'd12, 4'b0100, 1'b0, 99, -1, 7);

    cur_req = "R7 R11 parity";
    run_frame(4'd0, 4'b0100, 1'b1, 99, -1, 8);
    cur_req = "R8 R11 sync";
    run_frame(4'd1, 4'b0000, 1'b0, 99, -1, 9);
    cur_req = "R8 unknown ID";
    run_frame(4'd5, 4'b0100, 1'b0, 99, -1, 10);
    cur_req = "R8 no reply";
    do_start();
    mdl_stall();
    repeat (TMO + 20) @(posedge clk);

    cur_req = "R9 gap timeout";
    run_frame(4'd3, 4'b0100, 1'b0, 4, -1, 11);
    cur_req = "R9 R11 delimiter";
    run_frame(4'd0, 4'b0100, 1'b0, 99, 1, 12);
    cur_req = "R9 line low";
    do_start();
    send_field({1'b1, 1'b1, 4'd2, 4'b0100}, k);
    mdl_field(k, {1'b1, 1'b1, 4'd2, 4'b0100});
    send_field(10'b0, k);
    mdl_field(k, 10'b0);
    repeat (LAT) @(posedge clk);

    cur_req = "R6 R10 recovery";
    run_frame(4'd3, 4'b0100, 1'b0, 99, -1, 13);
    cur_req = "R1 reset";
    do_reset();
    repeat (10) @(posedge clk);

    if (evq.size() != 0) begin
      n_bad++;
      $display("FAIL R10 pending model events actual=%0d expected=0", evq.size());
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule